// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits behind the bus port of a flash controller. It turns bus write cycles into flash commands. Each write is one clock cycle with the write strobe high; it carries an address and a data byte. The decoder follows a multi-cycle unlock handshake. When a sequence completes it raises a one-cycle pulse for one of six commands: reset to read mode, byte program, chip erase, sector erase, erase suspend or erase resume. A program pulse carries the latched target address and data byte. A sector-erase pulse carries the sector number.

The decoder also keeps two mode flags. `busy` is set while an embedded operation started by this block is running. `suspended` is set while a sector erase is paused. The embedded-operation engine that consumes the pulses raises `op_done` for one cycle when it finishes, and that clears `busy`. A wrong write at any step drops the decoder back to read mode, and the next write is decoded as a first cycle. While an operation runs, only the suspend code is looked at, and it is honoured only during a sector erase.

The reset input is asserted asynchronously and released through a two-stage synchronizer. Every pulse appears in the clock cycle after the edge that sampled the write that caused it.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, all command pulses are low and `busy` and `suspended` are both 0.
- R2: An unlock is data AAh at address 555h followed by data 55h at address 2AAh. Both addresses are compared on the low 11 address bits only; the upper bits are ignored.
- R3: After an unlock, data A0h at 555h arms program mode. The next write, of any address and data, raises `cmd_program`. `prog_addr` and `prog_data` equal that write's address and data, and `busy` becomes 1.
- R4: After an unlock, the sequence 80h at 555h, AAh at 555h, 55h at 2AAh, then 10h at 555h raises `cmd_chip_erase` and sets `busy`.
- R5: The same erase setup ending in 30h at any address raises `cmd_sector_erase` and sets `busy`. `sector_addr` equals address bits [17:12] of that last write.
- R6: Data F0h at any address raises `cmd_reset` and returns the decoder to read mode. This holds when no operation runs and program mode is not armed; in program mode, F0h is simply program data.
- R7: A write with the wrong address or data at any step returns the decoder to read mode with no pulse, and the following write is decoded as a first cycle.
- R8: While `busy` is 1, every write other than an accepted suspend has no effect. `op_done` clears `busy`.
- R9: Data B0h at any address while a sector erase runs raises `cmd_suspend`, clears `busy` and sets `suspended`. At any other time B0h has no effect.
- R10: Data 30h at any address in read mode, while `suspended` is 1 and `busy` is 0, raises `cmd_resume`, clears `suspended` and sets `busy`. With `suspended` at 0, that write has no effect.
- R11: While `suspended` is 1, the last write of a chip or sector erase sequence returns to read mode with no pulse. A byte program is still accepted, and B0h during it has no effect.
- R12: Each pulse lasts exactly one cycle and appears in the cycle after the sampling edge of its write. At most one pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W (18) | Write address |
| wr_data | input | 8 | Write data byte |
| op_done | input | 1 | Embedded operation finished |
| cmd_reset | output | 1 | Reset-to-read pulse |
| cmd_program | output | 1 | Byte program pulse |
| prog_addr | output | ADDR_W (18) | Address of the byte to program |
| prog_data | output | 8 | Byte to program |
| cmd_chip_erase | output | 1 | Chip erase pulse |
| cmd_sector_erase | output | 1 | Sector erase pulse |
| sector_addr | output | SECT_W (6) | Sector to erase |
| cmd_suspend | output | 1 | Erase suspend pulse |
| cmd_resume | output | 1 | Erase resume pulse |
| busy | output | 1 | Embedded operation running |
| suspended | output | 1 | Sector erase paused |

## Verification
The bench builds the decoder with its default parameters: an 18-bit address, 11 matched bits and 6 sector bits. With these values the 7 upper address bits can be swept in full around both unlock addresses. The bench also sweeps all 256 data codes at the first unlock cycle, at the third cycle and at the final erase cycle. Each sweep predicts, for every code, which of abort, reset, program, chip erase or sector erase must follow. The suspend, resume and program-during-suspend interplay is driven as explicit sequences, with `busy` and `suspended` checked after each write.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int NUM_CODES = 8;
  localparam int IX_AA = 0;
  localparam int IX_55 = 1;
  localparam int IX_A0 = 2;
  localparam int IX_80 = 3;
  localparam int IX_10 = 4;
  localparam int IX_30 = 5;
  localparam int IX_F0 = 6;
  localparam int IX_B0 = 7;
  // code byte i sits at bits [8*i +: 8]
  localparam logic [NUM_CODES*8-1:0] CODE_TBL =
    {8'hB0, 8'hF0, 8'h30, 8'h10, 8'h80, 8'hA0, 8'h55, 8'hAA};
  localparam logic [10:0] KEY_FIRST  = 11'h555;
  localparam logic [10:0] KEY_SECOND = 11'h2AA;

  typedef enum logic [2:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PGM, ST_ERS1, ST_ERS2, ST_ERS3
  } seq_state_t;

  typedef struct packed {
    logic                 lo_a;  // low bits match first key
    logic                 lo_b;  // low bits match second key
    logic [NUM_CODES-1:0] hit;   // data equals code i
  } pair_t;

  typedef struct packed {
    logic rst;
    logic pgm;
    logic chip;
    logic sect;
    logic susp;
    logic resm;
  } cmd_evt_t;
endpackage

// File: rtl/fcd_rst_sync.sv
module fcd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/fcd_pair_decode.sv
module fcd_pair_decode
  import fcd_pkg::*;
#(
  parameter int MATCH_W = 11
) (
  input  logic [MATCH_W-1:0] addr_lo,
  input  logic [7:0]         data,
  output pair_t              pair
);
  localparam logic [MATCH_W-1:0] KEY_A = MATCH_W'(KEY_FIRST);
  localparam logic [MATCH_W-1:0] KEY_B = MATCH_W'(KEY_SECOND);

  logic [NUM_CODES-1:0] hit_w;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
    assign hit_w[i] = (data == CODE_TBL[8*i +: 8]);
  end

  always_comb begin
    pair.lo_a = (addr_lo == KEY_A);
    pair.lo_b = (addr_lo == KEY_B);
    pair.hit  = hit_w;
  end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  pair_t    pair,
  input  logic     busy,
  input  logic     erase_running,
  input  logic     suspended,
  output cmd_evt_t evt
);
  seq_state_t state_q, state_d;
  logic at_a, at_b;

  assign at_a = pair.lo_a;
  assign at_b = pair.lo_b;

  always_comb begin
    state_d = state_q;
    evt     = '0;
    if (wr_en) begin
      if (busy) begin
        if (erase_running && pair.hit[IX_B0]) evt.susp = 1'b1;
      end else begin
        state_d = ST_READ;
        if (state_q == ST_PGM) begin
          evt.pgm = 1'b1;
        end else if (pair.hit[IX_F0]) begin
          evt.rst = 1'b1;
        end else begin
          unique case (state_q)
            ST_READ: begin
              if (at_a && pair.hit[IX_AA])            state_d = ST_UNL1;
              else if (suspended && pair.hit[IX_30])  evt.resm = 1'b1;
            end
            ST_UNL1: if (at_b && pair.hit[IX_55]) state_d = ST_UNL2;
            ST_UNL2: begin
              if (at_a && pair.hit[IX_A0])      state_d = ST_PGM;
              else if (at_a && pair.hit[IX_80]) state_d = ST_ERS1;
            end
            ST_ERS1: if (at_a && pair.hit[IX_AA]) state_d = ST_ERS2;
            ST_ERS2: if (at_b && pair.hit[IX_55]) state_d = ST_ERS3;
            ST_ERS3: begin
              if (!suspended) begin
                if (at_a && pair.hit[IX_10]) evt.chip = 1'b1;
                else if (pair.hit[IX_30])    evt.sect = 1'b1;
              end
            end
            default: state_d = ST_READ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_READ;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/fcd_op_state.sv
module fcd_op_state
  import fcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cmd_evt_t evt,
  input  logic     op_done,
  output logic     busy,
  output logic     suspended,
  output logic     erase_running
);
  logic busy_q, busy_d;
  logic susp_q, susp_d;
  logic sect_q, sect_d;

  always_comb begin
    busy_d = busy_q;
    susp_d = susp_q;
    sect_d = sect_q;
    if (evt.pgm || evt.chip) begin
      busy_d = 1'b1;
      sect_d = 1'b0;
    end
    if (evt.sect || evt.resm) begin
      busy_d = 1'b1;
      sect_d = 1'b1;
    end
    if (evt.resm) susp_d = 1'b0;
    if (evt.susp) begin
      busy_d = 1'b0;
      susp_d = 1'b1;
    end else if (busy_q && op_done) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      susp_q <= 1'b0;
      sect_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      susp_q <= susp_d;
      sect_q <= sect_d;
    end
  end

  assign busy          = busy_q;
  assign suspended     = susp_q;
  assign erase_running = busy_q & sect_q;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int MATCH_W = 11,
  parameter int SECT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              op_done,
  output logic              cmd_reset,
  output logic              cmd_program,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              cmd_chip_erase,
  output logic              cmd_sector_erase,
  output logic [SECT_W-1:0] sector_addr,
  output logic              cmd_suspend,
  output logic              cmd_resume,
  output logic              busy,
  output logic              suspended
);
  localparam int SECT_LSB = ADDR_W - SECT_W;

  logic     rst_i_n;
  pair_t    pair;
  cmd_evt_t evt;
  cmd_evt_t pulse_q;
  logic     erase_running;

  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [7:0]        pd_q, pd_d;
  logic [SECT_W-1:0] sa_q, sa_d;

  fcd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  fcd_pair_decode #(.MATCH_W(MATCH_W)) u_pair (
    .addr_lo (wr_addr[MATCH_W-1:0]),
    .data    (wr_data),
    .pair    (pair)
  );

  fcd_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_i_n),
    .wr_en         (wr_en),
    .pair          (pair),
    .busy          (busy),
    .erase_running (erase_running),
    .suspended     (suspended),
    .evt           (evt)
  );

  fcd_op_state u_ops (
    .clk           (clk),
    .rst_n         (rst_i_n),
    .evt           (evt),
    .op_done       (op_done),
    .busy          (busy),
    .suspended     (suspended),
    .erase_running (erase_running)
  );

  always_comb begin
    pa_d = pa_q;
    pd_d = pd_q;
    sa_d = sa_q;
    if (evt.pgm) begin
      pa_d = wr_addr;
      pd_d = wr_data;
    end
    if (evt.sect) sa_d = wr_addr[SECT_LSB +: SECT_W];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pulse_q <= '0;
      pa_q    <= '0;
      pd_q    <= '0;
      sa_q    <= '0;
    end else begin
      pulse_q <= evt;
      pa_q    <= pa_d;
      pd_q    <= pd_d;
      sa_q    <= sa_d;
    end
  end

  assign cmd_reset        = pulse_q.rst;
  assign cmd_program      = pulse_q.pgm;
  assign cmd_chip_erase   = pulse_q.chip;
  assign cmd_sector_erase = pulse_q.sect;
  assign cmd_suspend      = pulse_q.susp;
  assign cmd_resume       = pulse_q.resm;
  assign prog_addr        = pa_q;
  assign prog_data        = pd_q;
  assign sector_addr      = sa_q;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic cmd_reset,
  input logic cmd_program,
  input logic cmd_chip_erase,
  input logic cmd_sector_erase,
  input logic cmd_suspend,
  input logic cmd_resume,
  input logic busy,
  input logic suspended
);
  logic [5:0] pulses;
  logic       starts;

  assign pulses = {cmd_reset, cmd_program, cmd_chip_erase,
                   cmd_sector_erase, cmd_suspend, cmd_resume};
  assign starts = cmd_reset | cmd_program | cmd_chip_erase |
                  cmd_sector_erase | cmd_resume;

  p_onehot_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));

  p_pulse_after_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulses) |-> $past(wr_en));

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !starts);

  p_start_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_program | cmd_chip_erase | cmd_sector_erase) |-> busy);

  p_suspend_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_suspend |-> (suspended && !busy && $past(busy)));

  p_resume_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_resume |-> (busy && !suspended && $past(suspended) && !$past(busy)));

  p_no_erase_suspended_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_chip_erase | cmd_sector_erase) |-> !suspended);
endmodule

bind flash_cmd_decoder fcd_checker chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .wr_en            (wr_en),
  .cmd_reset        (cmd_reset),
  .cmd_program      (cmd_program),
  .cmd_chip_erase   (cmd_chip_erase),
  .cmd_sector_erase (cmd_sector_erase),
  .cmd_suspend      (cmd_suspend),
  .cmd_resume       (cmd_resume),
  .busy             (busy),
  .suspended        (suspended)
);

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
  localparam int AW = 18;
  localparam int SW = 6;
  // pulse vector {reset, program, chip, sector, suspend, resume}
  localparam logic [5:0] P_RST  = 6'b100000;
  localparam logic [5:0] P_PGM  = 6'b010000;
  localparam logic [5:0] P_CHIP = 6'b001000;
  localparam logic [5:0] P_SECT = 6'b000100;
  localparam logic [5:0] P_SUSP = 6'b000010;
  localparam logic [5:0] P_RESM = 6'b000001;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic op_done;
  logic cmd_reset, cmd_program, cmd_chip_erase, cmd_sector_erase;
  logic cmd_suspend, cmd_resume, busy, suspended;
  logic [AW-1:0] prog_addr;
  logic [7:0] prog_data;
  logic [SW-1:0] sector_addr;

  int total = 0;
  int bad = 0;
  logic [5:0] acc;
  logic [AW-1:0] got_pa;
  logic [7:0] got_pd;
  logic [SW-1:0] got_sa;

  always #10 clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .op_done(op_done), .cmd_reset(cmd_reset),
    .cmd_program(cmd_program), .prog_addr(prog_addr), .prog_data(prog_data),
    .cmd_chip_erase(cmd_chip_erase), .cmd_sector_erase(cmd_sector_erase),
    .sector_addr(sector_addr), .cmd_suspend(cmd_suspend),
    .cmd_resume(cmd_resume), .busy(busy), .suspended(suspended)
  );

  function automatic logic [5:0] pulses();
    return {cmd_reset, cmd_program, cmd_chip_erase, cmd_sector_erase,
            cmd_suspend, cmd_resume};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    acc = acc | pulses();
    if (cmd_program) begin
      got_pa = prog_addr;
      got_pd = prog_data;
    end
    if (cmd_sector_erase) got_sa = sector_addr;
  endtask

  task automatic finish_op();
    @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  task automatic unl();
    wr(18'h00555, 8'hAA);
    wr(18'h002AA, 8'h55);
  endtask

  task automatic erase_setup();
    unl();
    wr(18'h00555, 8'h80);
    unl();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; op_done = 1'b0;
    acc = '0; got_pa = '0; got_pd = '0; got_sa = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1 pulses after reset", 32'(pulses()), 0);
    chk("R1 busy after reset", 32'(busy), 0);
    chk("R1 suspended after reset", 32'(suspended), 0);

    // R3 basic program
    acc = '0; unl(); wr(18'h00555, 8'hA0); wr(18'h21234, 8'h5A);
    chk("R3 program pulse", 32'(acc), 32'(P_PGM));
    chk("R3 program address", 32'(got_pa), 32'h21234);
    chk("R3 program data", 32'(got_pd), 32'h5A);
    chk("R3 busy set", 32'(busy), 1);

    // R8 writes ignored while busy
    acc = '0; erase_setup(); wr(18'h00555, 8'h10); wr(18'h0, 8'hF0); wr(18'h0, 8'h30);
    chk("R8 no pulse while busy", 32'(acc), 0);
    chk("R8 still busy", 32'(busy), 1);
    finish_op();
    chk("R8 op_done clears busy", 32'(busy), 0);

    // R4 chip erase, R9 suspend ignored during chip erase
    acc = '0; erase_setup(); wr(18'h00555, 8'h10);
    chk("R4 chip erase pulse", 32'(acc), 32'(P_CHIP));
    acc = '0; wr(18'h00000, 8'hB0);
    chk("R9 suspend ignored in chip erase", 32'(acc), 0);
    chk("R9 busy kept in chip erase", 32'(busy), 1);
    finish_op();

    // R5 sector erase
    acc = '0; erase_setup(); wr(18'h3A123, 8'h30);
    chk("R5 sector erase pulse", 32'(acc), 32'(P_SECT));
    chk("R5 sector address", 32'(got_sa), 32'h3A);

    // R9 suspend during sector erase
    acc = '0; wr(18'h01234, 8'hB0);
    chk("R9 suspend pulse", 32'(acc), 32'(P_SUSP));
    chk("R9 busy cleared", 32'(busy), 0);
    chk("R9 suspended set", 32'(suspended), 1);

    // R11 erase refused while suspended
    acc = '0; erase_setup(); wr(18'h05000, 8'h30);
    erase_setup(); wr(18'h00555, 8'h10);
    chk("R11 no erase while suspended", 32'(acc), 0);
    chk("R11 not busy", 32'(busy), 0);

    // R11 program allowed while suspended, B0 ignored during it
    acc = '0; unl(); wr(18'h00555, 8'hA0); wr(18'h00777, 8'h3C);
    chk("R11 program while suspended", 32'(acc), 32'(P_PGM));
    chk("R11 program data", 32'(got_pd), 32'h3C);
    acc = '0; wr(18'h0, 8'hB0);
    chk("R11 B0 ignored in program", 32'(acc), 0);
    chk("R11 still suspended", 32'(suspended), 1);
    finish_op();

    // R10 resume
    acc = '0; wr(18'h00777, 8'h30);
    chk("R10 resume pulse", 32'(acc), 32'(P_RESM));
    chk("R10 busy set", 32'(busy), 1);
    chk("R10 suspended cleared", 32'(suspended), 0);
    acc = '0; wr(18'h0, 8'hB0);
    chk("R9 suspend after resume", 32'(acc), 32'(P_SUSP));
    acc = '0; wr(18'h0, 8'h30);
    chk("R10 second resume", 32'(acc), 32'(P_RESM));
    finish_op();

    // R9 idle suspend, R10 resume when not suspended
    acc = '0; wr(18'h0, 8'hB0); wr(18'h0, 8'h30);
    chk("R9 R10 idle B0 and 30 ignored", 32'(acc), 0);
    chk("R10 idle busy", 32'(busy), 0);
    chk("R9 idle suspended", 32'(suspended), 0);

    // R6 F0 reset
    acc = '0; wr(18'h2ABCD, 8'hF0);
    chk("R6 reset from read", 32'(acc), 32'(P_RST));
    acc = '0; wr(18'h00555, 8'hAA); wr(18'h0, 8'hF0);
    wr(18'h002AA, 8'h55); wr(18'h00555, 8'hA0); wr(18'h1, 8'h1);
    chk("R6 reset mid sequence aborts", 32'(acc), 32'(P_RST));
    acc = '0; unl(); wr(18'h00555, 8'hA0); wr(18'h00100, 8'hF0);
    chk("R6 F0 is data in program mode", 32'(acc), 32'(P_PGM));
    chk("R6 F0 program data", 32'(got_pd), 32'hF0);
    finish_op();

    // R2 low-bit mismatch
    acc = '0; wr(18'h00554, 8'hAA); wr(18'h002AA, 8'h55);
    wr(18'h00555, 8'hA0); wr(18'h1, 8'h1);
    chk("R2 R7 wrong low address bit", 32'(acc), 0);

    // R2 sweep of upper address bits
    for (int hi = 0; hi < 128; hi++) begin
      acc = '0;
      wr({7'(hi), 11'h555}, 8'hAA);
      wr({7'(127 - hi), 11'h2AA}, 8'h55);
      wr({7'(hi ^ 85), 11'h555}, 8'hA0);
      wr({7'(hi), 11'h042}, 8'(hi));
      chk($sformatf("R2 upper bits %0d", hi), 32'(acc), 32'(P_PGM));
      if (acc == P_PGM) finish_op();
    end

    // R7 sweep of first-cycle data
    for (int d = 0; d < 256; d++) begin
      logic [5:0] ex;
      acc = '0;
      wr(18'h00555, 8'(d)); wr(18'h002AA, 8'h55);
      wr(18'h00555, 8'hA0); wr(18'h00123, 8'h5A);
      ex = (d == 'hAA) ? P_PGM : (d == 'hF0) ? P_RST : 6'b0;
      chk($sformatf("R7 cycle1 data %0h", d), 32'(acc), 32'(ex));
      if (busy) finish_op();
    end

    // R7 R3 R4 sweep of third-cycle data
    for (int d = 0; d < 256; d++) begin
      logic [5:0] ex;
      acc = '0;
      unl(); wr(18'h00555, 8'(d));
      wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55); wr(18'h00555, 8'h10);
      ex = (d == 'hA0) ? P_PGM : (d == 'h80) ? P_CHIP :
           (d == 'hF0) ? P_RST : 6'b0;
      chk($sformatf("R7 cycle3 data %0h", d), 32'(acc), 32'(ex));
      if (d == 'hA0) chk("R3 armed program data", 32'(got_pd), 32'hAA);
      if (busy) finish_op();
    end

    // R4 R5 R7 sweep of final erase-cycle data
    for (int d = 0; d < 256; d++) begin
      logic [5:0] ex;
      acc = '0;
      erase_setup(); wr(18'h2D555, 8'(d));
      ex = (d == 'h10) ? P_CHIP : (d == 'h30) ? P_SECT :
           (d == 'hF0) ? P_RST : 6'b0;
      chk($sformatf("R5 cycle6 data %0h", d), 32'(acc), 32'(ex));
      if (d == 'h30) chk("R5 sweep sector address", 32'(got_sa), 32'h2D);
      if (busy) finish_op();
    end

    // R12 pulse lasts one cycle
    unl(); wr(18'h00555, 8'hA0);
    @(negedge clk);
    wr_addr = 18'h00009; wr_data = 8'h77; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R12 pulse in cycle after write", 32'(cmd_program), 1);
    @(negedge clk);
    chk("R12 pulse gone next cycle", 32'(cmd_program), 0);
    finish_op();

    summary();
    $finish;
  end
endmodule